// File: doc/BRIEF.md
# Three-wire bus arbitration controller

The block sits on the bus-owner side of a request / grant / acknowledge handshake. An alternate master raises the request line; the controller answers with grant, but only at a point where the local core reports that it is between bus cycles. The requester then raises acknowledge and, in the same cycle, drops its request. From that moment it owns the external bus until it lowers acknowledge again.

While an alternate master holds the bus, the controller tells the local core to keep off the address and strobe lines (`ext_master_o`), and more broadly to start no new cycle (`core_hold_o`). If a new request arrives while acknowledge is still held, grant is driven again at once, so outside logic can settle on the next master before the current one lets go. When acknowledge falls, grant drops for one cycle and the controller then either grants the waiting requester or gives the bus back to the core. Both asynchronous inputs pass through a synchronizer chain before the state machine sees them.

Top module: `bus_arb_ctrl`

## Requirements
- R1: After reset, `bus_grant_o`, `ext_master_o` and `core_hold_o` are all 0.
- R2: From the idle state, grant is driven only when the request is seen and `core_idle_i` is 1. With the default two synchronizer stages, a request changed just after rising edge 0 shows on `bus_grant_o` after edge 3. If `core_idle_i` only becomes 1 just after edge k, grant appears after edge max(3, k+1).
- R3: Acknowledge raised during grant sets `ext_master_o` to 1 and `bus_grant_o` to 0 after the third rising edge, and not before.
- R4: Acknowledge falling with no request pending clears `ext_master_o` after the third edge. `core_hold_o` stays 1 through one release cycle and falls after the fourth edge.
- R5: If the request is withdrawn during grant with no acknowledge, `bus_grant_o` and `core_hold_o` fall after the third edge.
- R6: A request seen while acknowledge is still held drives `bus_grant_o` to 1 after the second edge, with `ext_master_o` still 1. Grant drops again after the second edge once that request is withdrawn.
- R7: When acknowledge falls with a request pending, grant is 0 after the third edge, in the release cycle. It is 1 again after the fourth edge, and `core_hold_o` stays 1 throughout. The next acknowledge sets `ext_master_o` again three edges later.
- R8: `core_hold_o` is 1 in every state but idle, and `core_idle_i` has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request from an alternate master, active high, asynchronous |
| bus_ack_i | input | 1 | Grant acknowledge from the current alternate master, active high, asynchronous |
| core_idle_i | input | 1 | Local core is at a bus-cycle boundary |
| bus_grant_o | output | 1 | Bus grant to requesters |
| ext_master_o | output | 1 | An alternate master owns the bus; core must not drive address or strobes |
| core_hold_o | output | 1 | Core must start no new external cycle |

## Verification
The bench builds the block with its default of two synchronizer stages. At that depth every handshake edge reaches the outputs a fixed three edges later, and a re-grant appears two edges later, so each latency is checked at the exact edge and one edge before it. A sweep over core-busy lengths from 0 to 8 cycles covers both sides of the max(3, k+1) grant rule. Directed sequences cover request withdrawal, the early re-grant while the bus is held, and back-to-back ownership with no return to the core.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned N_ST = 4;
  localparam int unsigned S_IDLE  = 0;
  localparam int unsigned S_GRANT = 1;
  localparam int unsigned S_EXT   = 2;
  localparam int unsigned S_REL   = 3;
  typedef logic [N_ST-1:0] state_t;
  localparam state_t ST_RESET = state_t'(1) << S_IDLE;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] ff_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= '0;
        else         ff_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= '0;
        else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic ack_s_i,
  input  logic core_idle_i,
  output logic grant_o,
  output logic ext_o,
  output logic hold_o
);
  state_t st_q, st_d;

  always_comb begin
    st_d = '0;
    case (1'b1)
      st_q[S_IDLE]: begin
        if (ack_s_i)                      st_d[S_EXT]   = 1'b1;
        else if (req_s_i && core_idle_i)  st_d[S_GRANT] = 1'b1;
        else                              st_d[S_IDLE]  = 1'b1;
      end
      st_q[S_GRANT]: begin
        if (ack_s_i)       st_d[S_EXT]   = 1'b1;
        else if (!req_s_i) st_d[S_IDLE]  = 1'b1;
        else               st_d[S_GRANT] = 1'b1;
      end
      st_q[S_EXT]: begin
        if (!ack_s_i) st_d[S_REL] = 1'b1;
        else          st_d[S_EXT] = 1'b1;
      end
      st_q[S_REL]: begin
        if (ack_s_i)      st_d[S_EXT]   = 1'b1;
        else if (req_s_i) st_d[S_GRANT] = 1'b1;
        else              st_d[S_IDLE]  = 1'b1;
      end
      default: st_d[S_IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_RESET;
    else         st_q <= st_d;

  // early re-grant while the current owner still holds acknowledge
  assign grant_o = st_q[S_GRANT] | (st_q[S_EXT] & req_s_i);
  assign ext_o   = st_q[S_EXT];
  assign hold_o  = ~st_q[S_IDLE];

  onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot(st_q));

  // R2
  grant_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(grant_o) && $past(st_q[S_IDLE])) |-> $past(core_idle_i));

  // R3
  ext_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_o) |-> $past(ack_s_i));

  // R4
  ext_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_o) |-> !$past(ack_s_i));
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_i,
  input  logic bus_ack_i,
  input  logic core_idle_i,
  output logic bus_grant_o,
  output logic ext_master_o,
  output logic core_hold_o
);
  localparam int unsigned N_IN = 2;

  logic [N_IN-1:0] raw, synced;

  assign raw = {bus_ack_i, bus_req_i};

  arb_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  arb_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_s_i    (synced[0]),
    .ack_s_i    (synced[1]),
    .core_idle_i(core_idle_i),
    .grant_o    (bus_grant_o),
    .ext_o      (ext_master_o),
    .hold_o     (core_hold_o)
  );

  // R8
  hold_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_hold_o |-> (!bus_grant_o && !ext_master_o));

  // R3
  no_grant_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_master_o) |-> !bus_grant_o);
endmodule

// File: tb/bus_arb_ctrl_tb_top.sv
module bus_arb_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ack = 1'b0, idle = 1'b1;
  logic bg, ext, hold;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arb_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_ack_i(ack),
    .core_idle_i(idle), .bus_grant_o(bg), .ext_master_o(ext), .core_hold_o(hold)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int n, exp;
    step(2);
    chk("R1 grant", int'(bg), 0);
    chk("R1 ext", int'(ext), 0);
    chk("R1 hold", int'(hold), 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 grant after release", int'(bg), 0);

    // R2 / R3 / R4 sweep over core-busy lengths
    for (int k = 0; k <= 8; k++) begin
      idle = (k == 0);
      req  = 1'b1;
      n = 0;
      while (!bg && n < 20) begin
        step(1);
        n++;
        if (n == k) idle = 1'b1;
      end
      exp = (k + 1 > 3) ? k + 1 : 3;
      chk($sformatf("R2 grant latency k=%0d", k), n, exp);
      ack = 1'b1; req = 1'b0;
      step(2);
      chk("R3 ext early", int'(ext), 0);
      step(1);
      chk("R3 ext", int'(ext), 1);
      chk("R3 grant off", int'(bg), 0);
      ack = 1'b0;
      step(3);
      chk("R4 ext off", int'(ext), 0);
      chk("R4 hold release", int'(hold), 1);
      step(1);
      chk("R4 hold off", int'(hold), 0);
      step(2);
    end

    // R5 withdrawal
    req = 1'b1;
    step(3);
    chk("R5 grant up", int'(bg), 1);
    req = 1'b0;
    step(2);
    chk("R5 grant held", int'(bg), 1);
    step(1);
    chk("R5 grant off", int'(bg), 0);
    chk("R5 hold off", int'(hold), 0);

    // R6 early re-grant, R8 idle ignored
    req = 1'b1;
    step(3);
    ack = 1'b1; req = 1'b0;
    step(3);
    chk("R6 ext", int'(ext), 1);
    idle = 1'b0;
    step(2);
    chk("R8 ext ignores idle", int'(ext), 1);
    chk("R8 hold", int'(hold), 1);
    idle = 1'b1;
    req = 1'b1;
    step(1);
    chk("R6 regrant early", int'(bg), 0);
    step(1);
    chk("R6 regrant", int'(bg), 1);
    chk("R6 ext kept", int'(ext), 1);
    req = 1'b0;
    step(2);
    chk("R6 regrant withdrawn", int'(bg), 0);
    req = 1'b1;
    step(2);
    chk("R6 regrant again", int'(bg), 1);

    // R7 handover
    ack = 1'b0;
    step(3);
    chk("R7 release grant", int'(bg), 0);
    chk("R7 release hold", int'(hold), 1);
    chk("R7 release ext", int'(ext), 0);
    step(1);
    chk("R7 regrant", int'(bg), 1);
    chk("R7 hold", int'(hold), 1);
    ack = 1'b1; req = 1'b0;
    step(2);
    chk("R7 ext early", int'(ext), 0);
    chk("R7 hold mid", int'(hold), 1);
    step(1);
    chk("R7 ext", int'(ext), 1);

    // R8 release with core busy, then request with core busy
    idle = 1'b0;
    ack = 1'b0;
    step(4);
    chk("R8 hold off", int'(hold), 0);
    req = 1'b1;
    step(6);
    chk("R8 R2 no grant busy", int'(bg), 0);
    idle = 1'b1;
    step(1);
    chk("R2 grant after idle", int'(bg), 1);
    req = 1'b0;
    step(4);
    finish_run();
  end
endmodule